// File: doc/BRIEF.md
# Exception State Register Bank

This block keeps the exception state of a 32-bit processor in four system-control registers. The first holds the faulting data address. The second is a status word with an interrupt mask and a three-level stack of mode/enable pairs. The third is a cause word with latched hardware-interrupt pending bits and a 4-bit exception code. The fourth holds the PC of the instruction to return to. The pipeline reports a synchronous exception by asserting a request together with a code, the current PC and, for address faults, the address that was referenced. External hardware interrupt lines are latched into the cause word. When interrupts are enabled and a pending line is unmasked, the block raises an interrupt-taken request.

On any exception or interrupt entry the block redirects fetch to a fixed handler address in the same cycle. On the following clock edge it updates all four registers together. A return-from-exception strobe pops the mode/enable stack. A move-from read port returns any of the four registers by register number. A move-to write port loads the status word and clears serviced pending bits in the cause word.

Top module: `exc_ctrl_regs`

## Requirements
- R1: While reset is held and right after it, all four registers read 0 and both `redirect_valid` and `irq_taken` are 0.
- R2: `rd_data` returns the faulting-address register for `rd_sel`=8, status for 12, cause for 13 and exception PC for 14. Any other selector returns 0.
- R3: In a cycle with `exc_req`=1, `redirect_valid`=1 and `redirect_pc`=0x80000080. After that edge, cause bits [5:2] equal `exc_code`.
- R4: On entry, status bits [5:0] become the old bits [3:0] followed by two zero bits, and the mask in status [15:8] is unchanged.
- R5: When `rfe`=1 and no entry occurs, status bits [5:0] become {s[5:4], s[5:4], s[3:2]} of the previous value.
- R6: On entry, the exception PC becomes `cur_pc`-4 when `pc_advanced`=1 and `cur_pc` when it is 0, with modulo-2^32 wrap.
- R7: The faulting-address register loads `bad_addr` only on a synchronous exception whose code is 4 (load/fetch address error) or 5 (store address error). Every other entry leaves it unchanged.
- R8: A high level on `hw_irq[i]` sets cause bit 10+i, and the bit stays set after the line drops, even with interrupts disabled. A write to register 13 keeps pending bit i only where `wr_data[10+i]`=1. A line that is still high sets its bit again in the same cycle.
- R9: `irq_taken`=1 exactly when status bit 0 is 1, no synchronous request is present, and some pending bit i has status mask bit 11+i set. An interrupt entry writes code 0.
- R10: When a synchronous request and an enabled interrupt occur in the same cycle, the synchronous exception wins: `irq_taken`=0, its code is recorded and the stack shifts only once.
- R11: A write to register 12 loads status bits [15:8] and [5:0] from `wr_data` when there is no entry or return in the same cycle. Status bits 31:16 and 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 4 | Code of the synchronous exception |
| cur_pc | input | 32 | PC of the instruction at the exception point |
| pc_advanced | input | 1 | `cur_pc` already points past the offending instruction |
| bad_addr | input | 32 | Address referenced by a faulting memory access |
| hw_irq | input | 5 | Hardware interrupt request lines |
| rfe | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Move-to register write strobe |
| wr_sel | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 5 | Register number for the read |
| rd_data | output | 32 | Read data |
| redirect_valid | output | 1 | Fetch must redirect to the handler this cycle |
| redirect_pc | output | 32 | Handler address |
| irq_taken | output | 1 | An external interrupt is taken this cycle |

## Verification
A synchronous exception and an enabled pending interrupt can arrive in the same cycle. The bench sets this up by latching a hardware line, unmasking it, and returning from an earlier entry so that the enable bit comes back. In the cycle where `irq_taken` first rises, it then drives a breakpoint request. The collision is judged at the ports: `irq_taken` must fall, the redirect must still be raised, the recorded code must be the breakpoint and not 0, the stack must have shifted once, and the pending bit must survive for later service.

// File: rtl/exc_regs_pkg.sv
package exc_regs_pkg;

   localparam int unsigned SEL_W = 5;

   localparam logic [SEL_W-1:0] SEL_BADADDR = 5'd8;
   localparam logic [SEL_W-1:0] SEL_STATUS  = 5'd12;
   localparam logic [SEL_W-1:0] SEL_CAUSE   = 5'd13;
   localparam logic [SEL_W-1:0] SEL_EPC     = 5'd14;

   localparam int unsigned STACK_W   = 6;
   localparam int unsigned MASK_LSB  = 8;
   localparam int unsigned PEND_LSB  = 10;
   localparam int unsigned CODE_LSB  = 2;
   localparam int unsigned CODE_W    = 4;

   typedef enum logic [CODE_W-1:0] {
      EC_INT     = 4'd0,
      EC_ADDR_LD = 4'd4,
      EC_ADDR_ST = 4'd5,
      EC_IBUS    = 4'd6,
      EC_DBUS    = 4'd7,
      EC_SYSCALL = 4'd8,
      EC_BREAK   = 4'd9,
      EC_RSVD    = 4'd10,
      EC_OVF     = 4'd12
   } exc_code_e;

   function automatic logic is_addr_fault(input logic [CODE_W-1:0] c);
      return (c == EC_ADDR_LD) || (c == EC_ADDR_ST);
   endfunction

endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack
   import exc_regs_pkg::*;
#(
   parameter int unsigned MASK_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enter_i,
   input  logic               rfe_i,
   input  logic               wr_en_i,
   input  logic [MASK_W-1:0]  wr_mask_i,
   input  logic [STACK_W-1:0] wr_stack_i,
   output logic [MASK_W-1:0]  mask_o,
   output logic [STACK_W-1:0] stack_o
);

   logic [MASK_W-1:0]  mask_q;
   logic [STACK_W-1:0] stack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         stack_q <= '0;
      end else if (enter_i) begin
         stack_q <= {stack_q[3:0], 2'b00};
      end else if (rfe_i) begin
         stack_q <= {stack_q[5:4], stack_q[5:4], stack_q[3:2]};
      end else if (wr_en_i) begin
         mask_q  <= wr_mask_i;
         stack_q <= wr_stack_i;
      end
   end

   assign mask_o  = mask_q;
   assign stack_o = stack_q;

   // R4
   stat_enter_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> (stack_q[1:0] == 2'b00) && (stack_q[3:2] == $past(stack_q[1:0]))
                  && (mask_q == $past(mask_q)));

   // R5
   stat_rfe_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe_i && !enter_i) |=> (stack_q[1:0] == $past(stack_q[3:2]))
                              && (stack_q[5:4] == $past(stack_q[5:4])));

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
   import exc_regs_pkg::*;
#(
   parameter int unsigned NUM_HW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_HW-1:0] hw_irq_i,
   input  logic              enter_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              clr_en_i,
   input  logic [NUM_HW-1:0] clr_keep_i,
   output logic [NUM_HW-1:0] pend_o,
   output logic [CODE_W-1:0] code_o
);

   logic [CODE_W-1:0] code_q;

   for (genvar i = 0; i < NUM_HW; i++) begin : g_pend
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= (clr_en_i ? (bit_q & clr_keep_i[i]) : bit_q) | hw_irq_i[i];
      end
      assign pend_o[i] = bit_q;

      // R8
      pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_q && !clr_en_i) |=> bit_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       code_q <= '0;
      else if (enter_i) code_q <= code_i;
   end

   assign code_o = code_q;

   // R3
   cause_code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> code_o == $past(code_i));

endmodule

// File: rtl/exc_capture_regs.sv
module exc_capture_regs #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned INSTR_BYTES = 4,
   parameter bit          EPC_REWIND  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enter_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            pc_adv_i,
   input  logic            bad_en_i,
   input  logic [XLEN-1:0] bad_addr_i,
   output logic [XLEN-1:0] epc_o,
   output logic [XLEN-1:0] badaddr_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

   logic [XLEN-1:0] epc_q, bad_q, epc_d;

   if (EPC_REWIND) begin : g_rewind
      assign epc_d = pc_adv_i ? (pc_i - STEP) : pc_i;
   end else begin : g_plain
      logic unused_adv;
      assign unused_adv = pc_adv_i;
      assign epc_d      = pc_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q <= '0;
         bad_q <= '0;
      end else if (enter_i) begin
         epc_q <= epc_d;
         if (bad_en_i) bad_q <= bad_addr_i;
      end
   end

   assign epc_o     = epc_q;
   assign badaddr_o = bad_q;

   // R7
   bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(enter_i && bad_en_i) |=> $stable(badaddr_o));

   // R6
   epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_i && !pc_adv_i) |=> epc_o == $past(pc_i));

endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
   import exc_regs_pkg::*;
#(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     NUM_HW     = 5,
   parameter int unsigned     NUM_SW     = 3,
   parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic [3:0]        exc_code,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic              pc_advanced,
   input  logic [XLEN-1:0]   bad_addr,
   input  logic [NUM_HW-1:0] hw_irq,
   input  logic              rfe,
   input  logic              wr_en,
   input  logic [4:0]        wr_sel,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [4:0]        rd_sel,
   output logic [XLEN-1:0]   rd_data,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc,
   output logic              irq_taken
);

   localparam int unsigned MASK_W = NUM_HW + NUM_SW;

   if (XLEN < 16) begin : g_bad_xlen
      $error("exc_ctrl_regs: XLEN must be at least 16");
   end
   if (MASK_W != 8) begin : g_bad_mask
      $error("exc_ctrl_regs: NUM_HW + NUM_SW must be 8");
   end
   if (NUM_HW > 5) begin : g_bad_hw
      $error("exc_ctrl_regs: at most 5 hardware lines fit the cause layout");
   end

   logic [MASK_W-1:0]  mask;
   logic [STACK_W-1:0] stack;
   logic [NUM_HW-1:0]  pend;
   logic [CODE_W-1:0]  code;
   logic [XLEN-1:0]    epc, badaddr;
   logic               irq_req, enter, bad_en, wr_stat, wr_cause;
   logic [CODE_W-1:0]  code_sel;

   assign irq_req   = stack[0] & (|(pend & mask[NUM_SW +: NUM_HW]));
   assign enter     = exc_req | irq_req;
   assign irq_taken = irq_req & ~exc_req;
   assign code_sel  = exc_req ? exc_code : EC_INT;
   assign bad_en    = exc_req & is_addr_fault(exc_code);
   assign wr_stat   = wr_en && (wr_sel == SEL_STATUS);
   assign wr_cause  = wr_en && (wr_sel == SEL_CAUSE);

   assign redirect_valid = enter;
   assign redirect_pc    = HANDLER_PC;

   exc_status_stack #(.MASK_W(MASK_W)) i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .enter_i    (enter),
      .rfe_i      (rfe),
      .wr_en_i    (wr_stat),
      .wr_mask_i  (wr_data[MASK_LSB +: MASK_W]),
      .wr_stack_i (wr_data[STACK_W-1:0]),
      .mask_o     (mask),
      .stack_o    (stack)
   );

   exc_cause_reg #(.NUM_HW(NUM_HW)) i_cause (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_irq_i   (hw_irq),
      .enter_i    (enter),
      .code_i     (code_sel),
      .clr_en_i   (wr_cause),
      .clr_keep_i (wr_data[PEND_LSB +: NUM_HW]),
      .pend_o     (pend),
      .code_o     (code)
   );

   exc_capture_regs #(.XLEN(XLEN)) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .enter_i    (enter),
      .pc_i       (cur_pc),
      .pc_adv_i   (pc_advanced),
      .bad_en_i   (bad_en),
      .bad_addr_i (bad_addr),
      .epc_o      (epc),
      .badaddr_o  (badaddr)
   );

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_BADADDR: rd_data = badaddr;
         SEL_STATUS: begin
            rd_data[MASK_LSB +: MASK_W] = mask;
            rd_data[STACK_W-1:0]        = stack;
         end
         SEL_CAUSE: begin
            rd_data[PEND_LSB +: NUM_HW] = pend;
            rd_data[CODE_LSB +: CODE_W] = code;
         end
         SEL_EPC:     rd_data = epc;
         default:     rd_data = '0;
      endcase
   end

   // R9
   irq_entry_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_taken |=> (code == EC_INT) && (stack[1:0] == 2'b00));

   // R10
   sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && irq_req) |=> (code == $past(exc_code)) && (stack[3:2] == $past(stack[1:0])));

endmodule

// File: tb/test_exc_ctrl_regs.sv
module test_exc_ctrl_regs;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 4;
   localparam logic [31:0] V_PC   [NV] = '{32'h0040_0010, 32'h0040_0104, 32'h0000_0000, 32'h0040_1000};
   localparam logic        V_ADV  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1};
   localparam logic [3:0]  V_CODE [NV] = '{4'd12, 4'd4, 4'd5, 4'd10};
   localparam logic [31:0] V_BAD  [NV] = '{32'hDEAD_0000, 32'h1000_0003, 32'h7FFF_FFFE, 32'h0000_1234};
   localparam logic [5:0]  V_STK  [NV] = '{6'b000001, 6'b000011, 6'b110110, 6'b101001};

   logic        clk = 0, rst_n = 0;
   logic        exc_req = 0, pc_advanced = 0, rfe = 0, wr_en = 0;
   logic [3:0]  exc_code = 0;
   logic [31:0] cur_pc = 0, bad_addr = 0, wr_data = 0;
   logic [4:0]  hw_irq = 0, wr_sel = 0, rd_sel = 0;
   logic [31:0] rd_data, redirect_pc;
   logic        redirect_valid, irq_taken;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_ctrl_regs i_exc_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
      .cur_pc(cur_pc), .pc_advanced(pc_advanced), .bad_addr(bad_addr),
      .hw_irq(hw_irq), .rfe(rfe), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .irq_taken(irq_taken)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic rdreg(input logic [4:0] s, output logic [31:0] v);
      rd_sel = s;
      #1;
      v = rd_data;
   endtask

   task automatic wreg(input logic [4:0] s, input logic [31:0] d);
      wr_en = 1; wr_sel = s; wr_data = d;
      tick;
      wr_en = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v, exp_bad;
      logic [5:0]  st;
      exp_bad = 0;

      // R1 reset state
      tick; tick;
      rdreg(5'd8, v);  chk("R1 badaddr", v, 0);
      rdreg(5'd12, v); chk("R1 status", v, 0);
      rdreg(5'd13, v); chk("R1 cause", v, 0);
      rdreg(5'd14, v); chk("R1 epc", v, 0);
      chk("R1 redirect_valid", {31'b0, redirect_valid}, 0);
      chk("R1 irq_taken", {31'b0, irq_taken}, 0);
      rst_n = 1;
      tick;
      chk("R1 redirect after reset", {31'b0, redirect_valid}, 0);

      // R11 status write
      wreg(5'd12, 32'hFFFF_FFC0 | 32'h0000_0015);
      rdreg(5'd12, v); chk("R11 status write", v, 32'h0000_FF15);

      // vector walk: R3 R4 R5 R6 R7
      for (int k = 0; k < NV; k++) begin
         wreg(5'd12, {16'h0, 8'hFF, 2'b00, V_STK[k]});
         exc_req = 1; exc_code = V_CODE[k]; cur_pc = V_PC[k];
         pc_advanced = V_ADV[k]; bad_addr = V_BAD[k];
         #1;
         chk("R3 redirect_valid", {31'b0, redirect_valid}, 1);
         chk("R3 redirect_pc", redirect_pc, 32'h8000_0080);
         chk("R9 no irq on sync", {31'b0, irq_taken}, 0);
         tick;
         exc_req = 0;
         if (V_CODE[k] == 4 || V_CODE[k] == 5) exp_bad = V_BAD[k];
         st = {V_STK[k][3:0], 2'b00};
         rdreg(5'd13, v); chk("R3 cause code", (v >> 2) & 32'hF, {28'b0, V_CODE[k]});
         rdreg(5'd12, v); chk("R4 status shift", v, {16'h0, 8'hFF, 2'b00, st});
         rdreg(5'd14, v); chk("R6 epc", v, V_ADV[k] ? V_PC[k] - 32'd4 : V_PC[k]);
         rdreg(5'd8, v);  chk("R7 badaddr", v, exp_bad);
         rfe = 1;
         tick;
         rfe = 0;
         rdreg(5'd12, v); chk("R5 rfe pop", v, {16'h0, 8'hFF, 2'b00, st[5:4], st[5:4], st[3:2]});
      end

      // R8 pending latch with interrupts disabled
      wreg(5'd12, 32'h0);
      hw_irq = 5'b00100;
      tick;
      hw_irq = 0;
      rdreg(5'd13, v); chk("R8 pending set", v & 32'h7C00, 32'h1000);
      chk("R8 no irq while disabled", {31'b0, irq_taken}, 0);
      tick; tick; tick;
      rdreg(5'd13, v); chk("R8 pending sticky", v & 32'h7C00, 32'h1000);

      // R9 masked line gives no request
      wreg(5'd12, 32'h0000_1001);
      chk("R9 masked", {31'b0, irq_taken}, 0);
      chk("R9 masked redirect", {31'b0, redirect_valid}, 0);

      // R9 unmasked and enabled
      cur_pc = 32'h0040_0200; pc_advanced = 0;
      wreg(5'd12, 32'h0000_2001);
      chk("R9 irq_taken", {31'b0, irq_taken}, 1);
      chk("R9 redirect", {31'b0, redirect_valid}, 1);
      tick;
      rdreg(5'd12, v); chk("R9 status after irq entry", v, 32'h0000_2004);
      rdreg(5'd13, v); chk("R9 cause code 0", (v >> 2) & 32'hF, 0);
      rdreg(5'd14, v); chk("R9 epc", v, 32'h0040_0200);
      chk("R9 irq drops when disabled", {31'b0, irq_taken}, 0);

      // R10 collision: sync exception in the cycle irq_taken rises
      rfe = 1;
      tick;
      rfe = 0;
      chk("R10 irq raised again", {31'b0, irq_taken}, 1);
      exc_req = 1; exc_code = 4'd9; cur_pc = 32'h0040_0300; pc_advanced = 1;
      #1;
      chk("R10 irq_taken suppressed", {31'b0, irq_taken}, 0);
      chk("R10 redirect", {31'b0, redirect_valid}, 1);
      tick;
      exc_req = 0;
      rdreg(5'd13, v);
      chk("R10 code is breakpoint", (v >> 2) & 32'hF, 9);
      chk("R10 pending kept", v & 32'h7C00, 32'h1000);
      rdreg(5'd12, v); chk("R10 single shift", v, 32'h0000_2004);
      rdreg(5'd14, v); chk("R10 epc", v, 32'h0040_02FC);

      // R8 clearing by write
      wreg(5'd13, 32'h0);
      rdreg(5'd13, v); chk("R8 cleared", v & 32'h7C00, 0);
      hw_irq = 5'b00001;
      wreg(5'd13, 32'h0);
      hw_irq = 0;
      rdreg(5'd13, v); chk("R8 live line wins clear", v & 32'h7C00, 32'h0400);

      // R2 unused selectors
      rdreg(5'd0, v);  chk("R2 sel0", v, 0);
      rdreg(5'd9, v);  chk("R2 sel9", v, 0);
      rdreg(5'd15, v); chk("R2 sel15", v, 0);
      rdreg(5'd31, v); chk("R2 sel31", v, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule